// File: doc/BRIEF.md
# Multi-Mode Serial Port

This block is a byte-oriented serial port with a single 2-bit mode field. It runs clocked 8-bit transfers either as the master, driving its own shift clock, or as the slave, following a clock from outside. It also runs UART-style asynchronous frames with 7 or 8 data bits, and the parity bit can be left out or set to odd or even. A host reaches it through a small register port. Writing a byte to the data register starts a transfer in the current mode. A received byte, together with its error flags, waits in a holding register until the host reads it.

In the synchronous modes, data leaves least significant bit first. The outgoing bit changes on the falling edge of the shift clock and the incoming bit is sampled on the rising edge. As slave, the port pulls an active-low ready pin while a transfer is armed. In the asynchronous modes the receiver oversamples the line sixteen times per bit and takes each bit in the middle of its cell. One programmable divider supplies the master shift clock and the oversampling tick. All outputs are driven at all times.

Top module: `ser_port`

## Requirements
- R1: After reset the control register (address 0) reads 0, which is synchronous master mode with no parity. At the same time sdo and sclk_o are high, sclk_oe is high and rdy_n is high.
- R2: The mode field is control bits [1:0], and 00 selects master mode. In master mode, writing the data register (address 2) while idle shifts the byte out on sdo, least significant bit first, changing sdo on each falling edge of sclk_o. On each rising edge it samples sdi. After 8 bits the received byte reads back from address 3.
- R3: In master mode each high and each low half of sclk_o lasts DIV+1 clock cycles, where DIV is the value in register address 1.
- R4: In master mode rdy_n stays high throughout a transfer.
- R5: Mode 01 is slave mode. In slave mode sclk_oe is low and bits shift on the edges of sclk_i with the same polarity as in master mode. rdy_n goes low once the data register is written and returns high after the 8th rising edge.
- R6: Mode 11 sends an asynchronous frame on sdo: a low start bit, 8 data bits LSB first, an optional parity bit and a high stop bit. Each bit lasts 16*(DIV+1) cycles. A frame of the same shape on sdi is received and read from address 3.
- R7: Mode 10 does the same with 7 data bits, and bit 7 of a received byte reads 0.
- R8: Parity is control bits [3:2]. 0x means no parity bit, 10 means even parity (total of ones including parity is even) and 11 means odd parity.
- R9: Status (read at address 2) bit 2 is set when a received parity bit does not match the configured parity.
- R10: Status bit 3 is set when a received stop bit is low.
- R11: In the asynchronous modes sclk_oe is low, sclk_o holds high and rdy_n stays high.
- R12: Status bit 0 is busy and bit 1 is receive-full. Reading address 3 clears receive-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears receive-full at address 3) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data, one cycle after the strobe |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sclk_i | input | 1 | Shift clock from the pin (slave) |
| sclk_o | output | 1 | Shift clock to the pin (master) |
| sclk_oe | output | 1 | Clock pin drive enable |
| rdy_n | output | 1 | Active-low slave ready |

## Verification
Transmit and receive share the same cycles. In the synchronous modes one register shifts a bit in and a bit out on every edge pair. In the asynchronous modes the transmitter and the receiver run as separate engines. The bench drives each asynchronous case with an outgoing frame and an unrelated incoming frame started in the same cycle. It checks the transmitted frame bit by bit at mid-cell while its own frame, sometimes with bad parity or a low stop bit, is being decoded. Only after that does it read the received byte and the error flags. The synchronous sweeps use a slave pattern different from the transmitted byte, so a path that crosses bits over or shifts them in the wrong direction shows up as a mismatch on one side.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [1:0] {
    MD_MASTER = 2'b00,
    MD_SLAVE  = 2'b01,
    MD_ASYNC7 = 2'b10,
    MD_ASYNC8 = 2'b11
  } ser_mode_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DIV  = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_RX   = 2'd3;
endpackage

// File: rtl/ser_tick.sv
module ser_tick #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         master,
  input  logic         start,
  input  logic [W-1:0] tx_byte,
  input  logic         tick,
  input  logic         sclk_in,
  input  logic         sdi_in,
  output logic         sclk_q,
  output logic         sdo,
  output logic         rdy_n,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_byte
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic          sclk_prev;
  logic          fall_ev, rise_ev;

  // master paces edges from the divider; slave follows the pin
  assign fall_ev = master ? (tick && sclk_q)  : (sclk_prev && !sclk_in);
  assign rise_ev = master ? (tick && !sclk_q) : (!sclk_prev && sclk_in);
  assign rx_byte = sh;

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b1;
    else     sclk_prev <= sclk_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b1;
      sdo    <= 1'b1;
      rdy_n  <= 1'b1;
      busy   <= 1'b0;
      done   <= 1'b0;
      sh     <= '0;
      cnt    <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        sh     <= tx_byte;
        busy   <= 1'b1;
        cnt    <= '0;
        sclk_q <= 1'b1;
        rdy_n  <= master;
      end else if (busy) begin
        if (fall_ev) begin
          sdo <= sh[0];
          if (master) sclk_q <= 1'b0;
        end else if (rise_ev) begin
          sh  <= {sdi_in, sh[W-1:1]};
          cnt <= cnt + 1'b1;
          if (master) sclk_q <= 1'b1;
          if (cnt == CW'(W-1)) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            rdy_n <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ser_uart_tx.sv
module ser_uart_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         start,
  input  logic [W-1:0] data,
  input  logic         len8,
  input  logic         par_en,
  input  logic         par_odd,
  output logic         txd,
  output logic         busy
);
  localparam int FW = W + 3;
  localparam int LW = $clog2(FW + 1);
  localparam int NW = $clog2(W + 1);

  logic [FW-1:0] fr;
  logic [FW-2:0] sh;
  logic [LW-1:0] nbits, left;
  logic [NW-1:0] nd;
  logic [W-1:0]  mask;
  logic [3:0]    ph;

  always_comb begin
    nd    = len8 ? NW'(W) : NW'(W-1);
    mask  = len8 ? '1 : {1'b0, {(W-1){1'b1}}};
    fr    = '1;          // idle ones double as the stop bit
    fr[0] = 1'b0;
    for (int i = 0; i < W; i++)
      if (i < int'(nd)) fr[1+i] = data[i];
    if (par_en) fr[1+int'(nd)] = par_odd ^ (^(data & mask));
    nbits = LW'(nd) + LW'(par_en) + LW'(2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txd  <= 1'b1;
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
      ph   <= '0;
    end else if (start && !busy) begin
      sh   <= fr[FW-1:1];
      txd  <= fr[0];
      left <= nbits;
      ph   <= '0;
      busy <= 1'b1;
    end else if (busy && tick) begin
      ph <= ph + 1'b1;
      if (ph == 4'd15) begin
        if (left == LW'(1)) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          left <= left - 1'b1;
          txd  <= sh[0];
          sh   <= {1'b1, sh[FW-2:1]};
        end
      end
    end
  end
endmodule

// File: rtl/ser_uart_rx.sv
module ser_uart_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic         rxd,
  input  logic         len8,
  input  logic         par_en,
  input  logic         par_odd,
  output logic         done,
  output logic [W-1:0] data,
  output logic         perr,
  output logic         ferr
);
  localparam int SW = W + 1;
  localparam int CW = $clog2(SW + 1);
  localparam int NW = $clog2(W + 1);

  logic [SW-1:0] sh, tmp;
  logic [CW-1:0] cnt, k;
  logic [NW-1:0] nd;
  logic [W-1:0]  dec;
  logic          pe, act, hunt;
  logic [3:0]    ph;

  always_comb begin
    nd  = len8 ? NW'(W) : NW'(W-1);
    k   = CW'(nd) + CW'(par_en);
    tmp = sh >> (SW - int'(k));
    dec = tmp[W-1:0] & (len8 ? {W{1'b1}} : {1'b0, {(W-1){1'b1}}});
    pe  = par_en && (tmp[nd] != (par_odd ^ (^dec)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= 1'b0;
      hunt <= 1'b0;
      ph   <= '0;
      cnt  <= '0;
      sh   <= '0;
      done <= 1'b0;
      data <= '0;
      perr <= 1'b0;
      ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!act) begin
        if (en && !rxd) begin
          act  <= 1'b1;
          hunt <= 1'b1;
          ph   <= '0;
          cnt  <= '0;
        end
      end else if (tick) begin
        ph <= ph + 1'b1;
        if (hunt && ph == 4'd7) begin
          if (rxd) act <= 1'b0;        // glitch, not a start bit
          else begin
            hunt <= 1'b0;
            ph   <= '0;
          end
        end else if (!hunt && ph == 4'd15) begin
          if (cnt == k) begin
            act  <= 1'b0;
            done <= 1'b1;
            data <= dec;
            perr <= pe;
            ferr <= !rxd;
          end else begin
            sh  <= {rxd, sh[SW-1:1]};
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ser_port.sv
module ser_port
  import ser_pkg::*;
#(
  parameter int W       = 8,
  parameter int DIV_RST = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_we,
  input  logic         reg_re,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         sdi,
  output logic         sdo,
  input  logic         sclk_i,
  output logic         sclk_o,
  output logic         sclk_oe,
  output logic         rdy_n
);
  ser_mode_e    mode_q;
  logic [1:0]   par_q;
  logic [W-1:0] div_q, rx_q;
  logic         rx_full, perr_q, ferr_q;
  logic         sdi_m, sdi_s, sck_m, sck_s;
  logic         tick, is_async, is_master, busy_any, wr_data;
  logic         s_sclk, s_sdo, s_rdy, s_busy, s_done;
  logic [W-1:0] s_rx;
  logic         t_txd, t_busy;
  logic         r_done, r_perr, r_ferr;
  logic [W-1:0] r_data;

  assign is_async  = mode_q[1];
  assign is_master = (mode_q == MD_MASTER);
  assign busy_any  = s_busy | t_busy;
  assign wr_data   = reg_we && (reg_addr == A_DATA);

  always_ff @(posedge clk) begin
    if (rst) {sdi_m, sdi_s, sck_m, sck_s} <= 4'b1111;
    else     {sdi_m, sdi_s, sck_m, sck_s} <= {sdi, sdi_m, sclk_i, sck_m};
  end

  ser_tick #(.DW(W)) u_tick (.clk(clk), .rst(rst), .div(div_q), .tick(tick));

  ser_sync #(.W(W)) u_sync (
    .clk(clk), .rst(rst), .master(is_master),
    .start(wr_data && !is_async && !busy_any), .tx_byte(reg_wdata),
    .tick(tick), .sclk_in(sck_s), .sdi_in(sdi_s),
    .sclk_q(s_sclk), .sdo(s_sdo), .rdy_n(s_rdy), .busy(s_busy),
    .done(s_done), .rx_byte(s_rx));

  ser_uart_tx #(.W(W)) u_tx (
    .clk(clk), .rst(rst), .tick(tick),
    .start(wr_data && is_async && !busy_any), .data(reg_wdata),
    .len8(mode_q[0]), .par_en(par_q[1]), .par_odd(par_q[0]),
    .txd(t_txd), .busy(t_busy));

  ser_uart_rx #(.W(W)) u_rx (
    .clk(clk), .rst(rst), .en(is_async), .tick(tick), .rxd(sdi_s),
    .len8(mode_q[0]), .par_en(par_q[1]), .par_odd(par_q[0]),
    .done(r_done), .data(r_data), .perr(r_perr), .ferr(r_ferr));

  assign sdo     = is_async ? t_txd : s_sdo;
  assign sclk_o  = s_sclk;
  assign sclk_oe = is_master;
  assign rdy_n   = (mode_q == MD_SLAVE) ? s_rdy : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MD_MASTER;
      par_q   <= 2'b00;
      div_q   <= W'(DIV_RST);
      rx_q    <= '0;
      rx_full <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_CTRL) begin
        mode_q <= ser_mode_e'(reg_wdata[1:0]);
        par_q  <= reg_wdata[3:2];
      end
      if (reg_we && reg_addr == A_DIV) div_q <= reg_wdata;
      if (reg_re && reg_addr == A_RX) rx_full <= 1'b0;
      // a completing frame wins over a same-cycle read clear
      if (s_done) begin
        rx_q    <= s_rx;
        rx_full <= 1'b1;
        perr_q  <= 1'b0;
        ferr_q  <= 1'b0;
      end else if (r_done) begin
        rx_q    <= r_data;
        rx_full <= 1'b1;
        perr_q  <= r_perr;
        ferr_q  <= r_ferr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_CTRL:  reg_rdata <= W'({par_q, mode_q});
        A_DIV:   reg_rdata <= div_q;
        A_DATA:  reg_rdata <= W'({ferr_q, perr_q, rx_full, busy_any});
        default: reg_rdata <= rx_q;
      endcase
    end
  end
endmodule

// File: rtl/ser_port_chk.sv
module ser_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       busy,
  input logic       sclk_o,
  input logic       sdo,
  input logic       rdy_n,
  input logic [1:0] mode
);
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && !busy) |-> sclk_o); // R2

  AST_SCLK_PACED_BY_TICK: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && $past(mode) == 2'b00 && sclk_o != $past(sclk_o)) |-> $past(tick)); // R3

  AST_RDY_ARMS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && $fell(rdy_n)) |-> busy); // R5

  AST_RDY_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && $past(mode) == 2'b01 && $rose(rdy_n)) |-> !busy); // R5

  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && !busy) |-> sdo); // R6

  AST_ASYNC_SCLK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && $past(mode[1])) |-> $stable(sclk_o)); // R11
endmodule

bind ser_port ser_port_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .busy(busy_any),
  .sclk_o(sclk_o), .sdo(sdo), .rdy_n(rdy_n), .mode(mode_q));

// File: tb/sim_ser_port.sv
module sim_ser_port;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic sdi = 1'b1, sclk_i = 1'b1;
  logic sdo, sclk_o, sclk_oe, rdy_n;

  int vecs = 0, errs = 0;

  always #10 clk = ~clk;

  ser_port #(.W(W), .DIV_RST(3)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sdi(sdi), .sdo(sdo), .sclk_i(sclk_i), .sclk_o(sclk_o),
    .sclk_oe(sclk_oe), .rdy_n(rdy_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    int n = 0;
    do begin rd(2'd2, st); n++; end while (st[0] && n < 400);
  endtask

  task automatic mxfer(input logic [7:0] tx, input logic [7:0] sv, input int half);
    logic [7:0] got, rx;
    bit per_ok = 1, rdy_ok = 1;
    int t;
    wr(2'd2, tx);
    for (int i = 0; i < 8; i++) begin
      t = 0;
      while (sclk_o !== 1'b0 && t < 1000) begin @(negedge clk); t++; end
      got[i] = sdo; sdi = sv[i];
      t = 0;
      while (sclk_o !== 1'b1 && t < 1000) begin @(negedge clk); t++; if (rdy_n !== 1'b1) rdy_ok = 0; end
      if (t != half) per_ok = 0;
    end
    wait_idle();
    rd(2'd3, rx);
    chk(got == tx, "R2 master sdo bits", got, tx);
    chk(rx == sv, "R2 master sdi capture", rx, sv);
    chk(per_ok, "R3 sclk half period", 0, half);
    chk(rdy_ok, "R4 rdy_n in master", 0, 1);
  endtask

  task automatic sxfer(input logic [7:0] tx, input logic [7:0] sv);
    logic [7:0] got, rx;
    wr(2'd2, tx);
    chk(rdy_n === 1'b0, "R5 rdy_n armed", rdy_n, 0);
    for (int i = 0; i < 8; i++) begin
      sclk_i = 1'b0; sdi = sv[i];
      repeat (4) @(negedge clk);
      got[i] = sdo;
      sclk_i = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(rdy_n === 1'b1, "R5 rdy_n released", rdy_n, 1);
    rd(2'd3, rx);
    chk(got == tx, "R5 slave sdo bits", got, tx);
    chk(rx == sv, "R5 slave sdi capture", rx, sv);
  endtask

  function automatic logic par_of(input logic [7:0] d, input bit len8, input bit odd);
    logic [7:0] m = len8 ? d : {1'b0, d[6:0]};
    return odd ^ (^m);
  endfunction

  task automatic umon(input logic [7:0] tx, input bit len8, input bit pen, input bit podd, output bit ok);
    int nd = len8 ? 8 : 7;
    int t = 0;
    ok = 1;
    while (sdo !== 1'b0 && t < 100) begin @(negedge clk); t++; end
    repeat (8) @(negedge clk);
    if (sdo !== 1'b0) ok = 0;
    for (int i = 0; i < nd; i++) begin
      repeat (16) @(negedge clk);
      if (sdo !== tx[i]) ok = 0;
    end
    if (pen) begin
      repeat (16) @(negedge clk);
      if (sdo !== par_of(tx, len8, podd)) ok = 0;
    end
    repeat (16) @(negedge clk);
    if (sdo !== 1'b1) ok = 0;
  endtask

  task automatic udrive(input logic [7:0] r, input bit len8, input bit pen, input bit podd,
                        input bit badp, input bit bads);
    int nd = len8 ? 8 : 7;
    sdi = 1'b0; repeat (16) @(negedge clk);
    for (int i = 0; i < nd; i++) begin sdi = r[i]; repeat (16) @(negedge clk); end
    if (pen) begin sdi = par_of(r, len8, podd) ^ badp; repeat (16) @(negedge clk); end
    sdi = !bads; repeat (16) @(negedge clk);
    sdi = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [7:0] d, st;
    bit ok;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(sdo === 1'b1 && sclk_o === 1'b1, "R1 idle lines", {sdo, sclk_o}, 3);
    chk(sclk_oe === 1'b1 && rdy_n === 1'b1, "R1 oe/rdy", {sclk_oe, rdy_n}, 3);
    rd(2'd0, d);
    chk(d == 8'h00, "R1 ctrl reset", d, 0);

    // master sweep, all bytes, DIV=3
    wr(2'd1, 8'd3);
    for (int b = 0; b < 256; b++)
      mxfer(8'(b), 8'(b) ^ 8'h5A ^ 8'(b << 3), 4);
    // a second divider
    wr(2'd1, 8'd6);
    mxfer(8'hC3, 8'h3C, 7);

    // R12 receive-full set then cleared by data read
    mxfer(8'h81, 8'h7E, 7);
    rd(2'd2, st);
    chk(st[1] == 1'b0, "R12 rx_full cleared by read", st[1], 0);

    // slave mode
    wr(2'd0, 8'h01);
    @(negedge clk);
    chk(sclk_oe === 1'b0, "R5 sclk_oe in slave", sclk_oe, 0);
    chk(rdy_n === 1'b1, "R5 rdy_n idle", rdy_n, 1);
    for (int b = 0; b < 64; b++)
      sxfer(8'(b * 37 + 11), 8'(b * 53 + 200));
    rd(2'd2, st);
    chk(st[1] == 1'b0, "R12 rx_full after read", st[1], 0);

    // asynchronous modes, full duplex each frame, DIV=0
    wr(2'd1, 8'd0);
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 3; p++) begin
        bit len8 = (m == 0);
        logic [1:0] pf = (p == 0) ? 2'b00 : (p == 1 ? 2'b10 : 2'b11);
        bit pen = pf[1];
        bit podd = pf[0];
        string fr_tag = len8 ? "R6 frame 8-bit" : "R7 frame 7-bit";
        wr(2'd0, {4'b0, pf, 1'b1, len8});
        @(negedge clk);
        chk(sclk_oe === 1'b0 && rdy_n === 1'b1 && sclk_o === 1'b1, "R11 async pins",
            {sclk_oe, rdy_n, sclk_o}, 3);
        for (int j = 0; j < 16; j++) begin
          logic [7:0] tx = 8'(j * 29 + p * 7 + m * 3 + 1);
          logic [7:0] r  = 8'(~(j * 45 + 3));
          logic [7:0] rexp = len8 ? r : {1'b0, r[6:0]};
          bit badp = pen && (j % 5 == 3);
          bit bads = (j % 7 == 6);
          wr(2'd2, tx);
          fork
            umon(tx, len8, pen, podd, ok);
            udrive(r, len8, pen, podd, badp, bads);
          join
          chk(ok, pen ? "R8 parity in frame" : fr_tag, ok, 1);
          repeat (20) @(negedge clk);
          rd(2'd2, st);
          chk(st[1] == 1'b1, "R12 rx_full set", st[1], 1);
          chk(st[2] == badp, "R9 parity error flag", st[2], badp);
          chk(st[3] == bads, "R10 framing error flag", st[3], bads);
          rd(2'd3, d);
          chk(d == rexp, len8 ? "R6 rx byte" : "R7 rx byte", d, rexp);
        end
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule